// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Burst Mode

This block generates up to four independent pulse-width modulated outputs from a single clock that counts in 10 ns steps (100 MHz count rate). Software programs each channel through a small 32-bit register port with word addresses, a write strobe, a read strobe and registered read data. Per channel it sets an active time and a period, both in clock counts, an output polarity, and a run mode.

In continuous mode a started channel repeats its period until software stops it. In burst mode it emits a programmed number of periods, returns to its idle level and raises a sticky completion flag.

Timing values written while a channel runs are held in shadow registers. They reach the running counters only after a rising edge of that channel's update bit, and then only at the next period boundary, so a period is never cut short. A separate register drives the per-channel output-enable pins.

Top module: `pwm_multi`

## Requirements
- R1: After reset all registers read 0, `pwm_oe_o` is 0 and every `pwm_o` bit is 1, because polarity 0 makes the idle level high.
- R2: Word addresses are as follows. Active time of channel c is at 2c and its period at 2c+1. The control word is at 0x10, with polarity in bit c and mode in bit c+8. Start is at 0x11, done at 0x12, update at 0x13, the burst count of channel c at 0x14+c, and output enable at 0x34. A read with `re_i` high returns the addressed value on `rdata_o` after the next clock edge, and `rdata_o` holds while `re_i` is low.
- R3: A start bit written from 0 to 1 loads the active time H and period P and begins a period on the edge that samples the write. Each period lasts P clocks, and the output is at its active level for the first H clocks of it.
- R4: With polarity 1 the active level is high. With polarity 0 it is low. A stopped channel sits at the inactive level.
- R5: When H is greater than or equal to P, the output stays active for the whole period. When P is 0, the output stays idle.
- R6: Active-time and period writes to a running channel have no effect until an update bit goes from 0 to 1. The new values are applied at the next period boundary.
- R7: An update write that does not change the bit from 0 to 1, or that targets a stopped channel, has no effect.
- R8: Mode bit 1 selects burst mode. After the programmed count of whole periods, the channel goes idle and its done bit (bit c at 0x12) sets. The done bit stays set until the next rising edge of start, which clears it.
- R9: In burst mode a count of 0 produces no pulse and sets done on the start edge.
- R10: Clearing a start bit stops that channel on the sampling edge, and its output goes to the inactive level.
- R11: Bit c of the output-enable register drives `pwm_oe_o[c]`.
- R12: Writes to the done register have no effect.
- R13: Channels run independently, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, one count per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwm_o | output | NCH | Channel waveform outputs |
| pwm_oe_o | output | NCH | Per-channel output drive enables |

## Verification
The bench builds the block with its default four channels and 32-bit counts. It programs periods of only a few clocks, so that many period boundaries, shadow loads and complete bursts happen in a short run. Every channel is active at once with a different polarity and a different timing corner: H below P, H above P, a zero period, and a burst. This lets the per-cycle model catch any leak between channels or any wrong boundary cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DW = 32;
  localparam int AW = 6;

  localparam logic [AW-1:0] A_CTRL  = 6'h10;
  localparam logic [AW-1:0] A_START = 6'h11;
  localparam logic [AW-1:0] A_DONE  = 6'h12;
  localparam logic [AW-1:0] A_UPD   = 6'h13;
  localparam logic [AW-1:0] A_CNT0  = 6'h14;
  localparam logic [AW-1:0] A_OE    = 6'h34;

  typedef struct packed {
    logic [DW-1:0] high;
    logic [DW-1:0] per;
    logic [DW-1:0] cnt;
    logic          mode;
    logic          pol;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [NCH-1:0]      done_i,
  output ch_cfg_t [NCH-1:0]   cfg_o,
  output logic [NCH-1:0]      start_rise_o,
  output logic [NCH-1:0]      stop_o,
  output logic [NCH-1:0]      upd_rise_o,
  output logic [NCH-1:0]      oe_o
);
  logic [DW-1:0]  high_q [NCH];
  logic [DW-1:0]  per_q  [NCH];
  logic [DW-1:0]  cnt_q  [NCH];
  logic [NCH-1:0] pol_q, mode_q, start_q, upd_q, oe_q;
  logic [DW-1:0]  rd_val, rdata_q;

  wire wr_ctrl  = we_i && addr_i == A_CTRL;
  wire wr_start = we_i && addr_i == A_START;
  wire wr_upd   = we_i && addr_i == A_UPD;
  wire wr_oe    = we_i && addr_i == A_OE;

  assign start_rise_o = {NCH{wr_start}} & wdata_i[NCH-1:0] & ~start_q;
  assign stop_o       = {NCH{wr_start}} & ~wdata_i[NCH-1:0];
  assign upd_rise_o   = {NCH{wr_upd}} & wdata_i[NCH-1:0] & ~upd_q;
  assign oe_o         = oe_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_HI = AW'(2 * c);
    localparam logic [AW-1:0] A_PE = AW'(2 * c + 1);
    localparam logic [AW-1:0] A_CN = A_CNT0 + AW'(c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        high_q[c] <= '0;
        per_q[c]  <= '0;
        cnt_q[c]  <= '0;
      end else if (we_i) begin
        if (addr_i == A_HI) high_q[c] <= wdata_i;
        if (addr_i == A_PE) per_q[c]  <= wdata_i;
        if (addr_i == A_CN) cnt_q[c]  <= wdata_i;
      end
    end

    assign cfg_o[c].high = high_q[c];
    assign cfg_o[c].per  = per_q[c];
    assign cfg_o[c].cnt  = cnt_q[c];
    assign cfg_o[c].mode = mode_q[c];
    assign cfg_o[c].pol  = pol_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q   <= '0;
      mode_q  <= '0;
      start_q <= '0;
      upd_q   <= '0;
      oe_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        pol_q  <= wdata_i[NCH-1:0];
        mode_q <= wdata_i[8 +: NCH];
      end
      if (wr_start) start_q <= wdata_i[NCH-1:0];
      if (wr_upd)   upd_q   <= wdata_i[NCH-1:0];
      if (wr_oe)    oe_q    <= wdata_i[NCH-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(2 * c))     rd_val = high_q[c];
      if (addr_i == AW'(2 * c + 1)) rd_val = per_q[c];
      if (addr_i == A_CNT0 + AW'(c)) rd_val = cnt_q[c];
    end
    case (addr_i)
      A_CTRL: begin
        rd_val[NCH-1:0]  = pol_q;
        rd_val[8 +: NCH] = mode_q;
      end
      A_START: rd_val[NCH-1:0] = start_q;
      A_DONE:  rd_val[NCH-1:0] = done_i;
      A_UPD:   rd_val[NCH-1:0] = upd_q;
      A_OE:    rd_val[NCH-1:0] = oe_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R2
  AST_OE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_oe |=> oe_o == $past(wdata_i[NCH-1:0])); // R11
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ch_cfg_t cfg_i,
  input  logic    start_rise_i,
  input  logic    stop_i,
  input  logic    upd_rise_i,
  output logic    pwm_o,
  output logic    done_o
);
  logic          run_q, burst_q, pend_q, done_q;
  logic [DW-1:0] pos_q, act_high_q, act_per_q, target_q, pulses_q;

  // period ends when the next count would reach the period (P of 0 or 1 ends every clock)
  wire boundary = ({1'b0, pos_q} + 1'b1) >= {1'b0, act_per_q};
  wire zero_burst = cfg_i.mode && cfg_i.cnt == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      burst_q    <= 1'b0;
      pend_q     <= 1'b0;
      done_q     <= 1'b0;
      pos_q      <= '0;
      act_high_q <= '0;
      act_per_q  <= '0;
      target_q   <= '0;
      pulses_q   <= '0;
    end else if (start_rise_i) begin
      act_high_q <= cfg_i.high;
      act_per_q  <= cfg_i.per;
      burst_q    <= cfg_i.mode;
      target_q   <= cfg_i.cnt;
      pulses_q   <= '0;
      pos_q      <= '0;
      pend_q     <= 1'b0;
      run_q      <= !zero_burst;
      done_q     <= zero_burst;
    end else if (stop_i) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (run_q) begin
      pend_q <= upd_rise_i | (pend_q & ~boundary);
      if (boundary) begin
        pos_q <= '0;
        if (pend_q) begin
          act_high_q <= cfg_i.high;
          act_per_q  <= cfg_i.per;
        end
        if (burst_q) begin
          pulses_q <= pulses_q + 1'b1;
          if (pulses_q + 1'b1 == target_q) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pwm_o  = (run_q && act_per_q != '0 && pos_q < act_high_q) ? cfg_i.pol : ~cfg_i.pol;
  assign done_o = done_q;

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && act_per_q != '0 |-> pos_q < act_per_q); // R3
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !boundary && !start_rise_i |=> $stable(act_high_q) && $stable(act_per_q)); // R6
  AST_START_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rise_i && !zero_burst |=> !done_o && run_q); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_rise_i |=> done_o); // R8
  AST_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rise_i && zero_burst |=> done_o && !run_q); // R9
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_rise_i |=> pwm_o == ~cfg_i.pol); // R10
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [5:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic [NCH-1:0]  pwm_o,
  output logic [NCH-1:0]  pwm_oe_o
);
  ch_cfg_t [NCH-1:0] cfg;
  logic [NCH-1:0]    start_rise, stop, upd_rise, done;

  pwm_regfile #(.NCH(NCH)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .re_i         (re_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .done_i       (done),
    .cfg_o        (cfg),
    .start_rise_o (start_rise),
    .stop_o       (stop),
    .upd_rise_o   (upd_rise),
    .oe_o         (pwm_oe_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_channel i_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cfg_i        (cfg[c]),
      .start_rise_i (start_rise[c]),
      .stop_i       (stop[c]),
      .upd_rise_i   (upd_rise[c]),
      .pwm_o        (pwm_o[c]),
      .done_o       (done[c])
    );
  end
endmodule

// File: tb/test_pwm_multi.sv
module test_pwm_multi;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0, we = 0, re = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm, oe;
  int total = 0, bad = 0;
  string cur_req = "R1";
  bit cmp_on = 0, finished = 0;

  always #4 clk = ~clk;

  pwm_multi #(.NCH(NCH)) i_pwm_multi (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .pwm_oe_o(oe));

  // behavioural reference model
  logic [31:0] m_high[NCH], m_per[NCH], m_cnt[NCH];
  logic [31:0] m_ctrl, m_start, m_upd, m_oe, m_rdata;
  bit          m_run[NCH], m_burst[NCH], m_pend[NCH], m_done[NCH];
  longint      m_pos[NCH], m_ah[NCH], m_ap[NCH], m_goal[NCH], m_np[NCH];

  function automatic logic [31:0] m_read(logic [5:0] a);
    logic [31:0] v = 0;
    for (int c = 0; c < NCH; c++) begin
      if (a == 6'(2*c)) v = m_high[c];
      if (a == 6'(2*c+1)) v = m_per[c];
      if (a == 6'(8'h14 + c)) v = m_cnt[c];
      if (a == 6'h12) v[c] = m_done[c];
    end
    if (a == 6'h10) v = m_ctrl & 32'h0F0F;
    if (a == 6'h11) v = m_start;
    if (a == 6'h13) v = m_upd;
    if (a == 6'h34) v = m_oe;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_start = 0; m_upd = 0; m_oe = 0; m_rdata = 0;
      for (int c = 0; c < NCH; c++) begin
        m_high[c] = 0; m_per[c] = 0; m_cnt[c] = 0; m_run[c] = 0; m_burst[c] = 0;
        m_pend[c] = 0; m_done[c] = 0; m_pos[c] = 0; m_ah[c] = 0; m_ap[c] = 0;
        m_goal[c] = 0; m_np[c] = 0;
      end
    end else begin
      if (re) m_rdata = m_read(addr);
      for (int c = 0; c < NCH; c++) begin
        bit go, halt, upd, endp;
        go   = we && addr == 6'h11 && wdata[c] && !m_start[c];
        halt = we && addr == 6'h11 && !wdata[c];
        upd  = we && addr == 6'h13 && wdata[c] && !m_upd[c];
        if (go) begin
          m_ah[c] = m_high[c]; m_ap[c] = m_per[c]; m_burst[c] = m_ctrl[c+8];
          m_goal[c] = m_cnt[c]; m_np[c] = 0; m_pos[c] = 0; m_pend[c] = 0;
          if (m_burst[c] && m_goal[c] == 0) begin m_run[c] = 0; m_done[c] = 1; end
          else begin m_run[c] = 1; m_done[c] = 0; end
        end else if (halt) begin
          m_run[c] = 0; m_pend[c] = 0;
        end else if (m_run[c]) begin
          endp = (m_pos[c] + 1) >= m_ap[c];
          if (endp) begin
            m_pos[c] = 0;
            if (m_pend[c]) begin m_ah[c] = m_high[c]; m_ap[c] = m_per[c]; end
            if (m_burst[c]) begin
              m_np[c]++;
              if (m_np[c] == m_goal[c]) begin m_run[c] = 0; m_done[c] = 1; end
            end
          end else m_pos[c]++;
          m_pend[c] = upd || (m_pend[c] && !endp);
        end
      end
      if (we) begin
        for (int c = 0; c < NCH; c++) begin
          if (addr == 6'(2*c)) m_high[c] = wdata;
          if (addr == 6'(2*c+1)) m_per[c] = wdata;
          if (addr == 6'(8'h14 + c)) m_cnt[c] = wdata;
        end
        if (addr == 6'h10) m_ctrl = wdata;
        if (addr == 6'h11) m_start = wdata & 32'hF;
        if (addr == 6'h13) m_upd = wdata & 32'hF;
        if (addr == 6'h34) m_oe = wdata & 32'hF;
      end
    end
  end

  function automatic logic [NCH-1:0] m_wave();
    logic [NCH-1:0] w;
    for (int c = 0; c < NCH; c++) begin
      bit act = m_run[c] && m_ap[c] != 0 && m_pos[c] < m_ah[c];
      w[c] = act ? m_ctrl[c] : !m_ctrl[c];
    end
    return w;
  endfunction

  always @(negedge clk) if (cmp_on && rst_n) begin
    total++;
    if (pwm !== m_wave() || oe !== m_oe[NCH-1:0]) begin
      bad++;
      $display("FAIL %s pwm=%h oe=%h expected pwm=%h oe=%h t=%0t", cur_req, pwm, oe,
               m_wave(), m_oe[NCH-1:0], $time);
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0;
    check(rdata, m_rdata, "R2 readback");
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    check(32'(pwm), 32'hF, "R1 idle level");
    check(32'(oe), 32'h0, "R1 oe");
    rst_n = 1;
    idle(2);
    cmp_on = 1;
    cur_req = "R1";
    rd(6'h10); check(rdata, 0, "R1 ctrl");
    rd(6'h12); check(rdata, 0, "R1 done");

    cur_req = "R11";
    wr(6'h34, 32'hF);
    check(32'(oe), 32'hF, "R11 oe pins");

    cur_req = "R2";
    wr(6'h00, 3);  wr(6'h01, 8);
    wr(6'h02, 10); wr(6'h03, 5);
    wr(6'h04, 2);  wr(6'h05, 0);
    wr(6'h10, 32'h80D);
    rd(6'h00); check(rdata, 3, "R2 high ch0");
    rd(6'h03); rd(6'h05);
    rd(6'h10); check(rdata, 32'h80D, "R2 ctrl layout");

    cur_req = "R3 R4 R5 R13";
    wr(6'h11, 32'h7);
    idle(40);

    cur_req = "R6";
    wr(6'h00, 6); wr(6'h01, 10);
    idle(30);
    wr(6'h13, 1); wr(6'h13, 0);
    idle(30);

    cur_req = "R7";
    wr(6'h13, 1);
    idle(12);
    wr(6'h00, 2);
    wr(6'h13, 1);
    idle(30);
    wr(6'h13, 0);
    wr(6'h13, 8);
    idle(8);

    cur_req = "R8";
    wr(6'h06, 2); wr(6'h07, 4); wr(6'h17, 3);
    wr(6'h11, 32'hF);
    idle(20);
    rd(6'h12); check(rdata & 32'h8, 32'h8, "R8 done set");
    check(32'(pwm[3]), 0, "R8 idle after burst");

    cur_req = "R12";
    wr(6'h12, 0);
    rd(6'h12); check(rdata & 32'h8, 32'h8, "R12 done not writable");

    cur_req = "R8 restart";
    wr(6'h11, 32'h7); wr(6'h11, 32'hF);
    rd(6'h12); check(rdata & 32'h8, 0, "R8 done cleared by start");
    idle(20);

    cur_req = "R9";
    wr(6'h11, 32'hD);
    check(32'(pwm[1]), 1, "R10 ch1 stopped idle");
    wr(6'h10, 32'hA0D);
    wr(6'h15, 0);
    wr(6'h11, 32'hF);
    rd(6'h12); check(rdata & 32'h2, 32'h2, "R9 zero count done");
    check(32'(pwm[1]), 1, "R9 no pulse");
    idle(10);

    cur_req = "R10";
    wr(6'h11, 0);
    check(32'(pwm), 32'h2, "R10 all idle");
    idle(5);

    cmp_on = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule